// File: doc/BRIEF.md
# Asynchronous Receive Framer with Multi-Drop Wakeup

This block sits behind a bit-recovery stage in a serial receiver. Once per bit time it is handed one recovered line bit and a flag saying whether the samples for that bit disagreed. From that stream it finds start bits and shifts each character into an 11-bit shift register. It then places the completed data in a receive data register, with a separate ninth-bit output for 9-bit characters. It checks parity, watches for an idle line and reports receive events through status flags and two interrupt requests.

On a multi-drop line, software can put the receiver to sleep by setting a wakeup bit. While that bit is set, frames and idle lines raise no flags. Hardware clears the bit either on an idle line or on a frame that carries an address mark (its most significant data bit is 1). Software clears the data flags with one pulse and clears the idle flag with another.

Top module: `rx_framer`

## Requirements
- R1: With `nine_bit`=0 a frame is one start bit (0), 8 data bits sent least significant bit first, and one stop bit. `rx_data` takes the 8 data bits and `rx_bit8` reads 0. With `nine_bit`=1 there are 9 data bits, and the last one received appears on `rx_bit8`.
- R2: Two clock cycles after the `bit_stb` edge that carries the stop bit, the data register holds the new character and `full` is 1. A `clr_rx` pulse clears `full`, `overrun`, `noise`, `frame_err`, `parity_err` and `brk`.
- R3: `frame_err` is set together with `full` when the bit received in the stop position is 0.
- R4: `noise` is set together with `full` when any bit of the frame, from start to stop, arrived with `bit_noisy`=1. It is not set when the frame causes an overrun.
- R5: With `par_en`=1 the last data bit is the parity bit. `parity_err` is set when the count of ones over all data bits is odd with `par_odd`=0, or even with `par_odd`=1. With `par_en`=0, `parity_err` stays 0.
- R6: A frame that completes while `full` is 1 sets `overrun`. The old data is kept and the new data is discarded.
- R7: With `idle_after_stop`=0, the count of idle ones begins right after a start bit, so data and stop bits that are 1 also count. A run of ones as long as one frame (10 bits, or 11 with `nine_bit`=1) sets `idle`. This happens once after each received start bit.
- R8: With `idle_after_stop`=1, ones are counted only after the stop bit, so a full frame's length of ones must follow the stop bit before `idle` is set.
- R9: While `rwu` is 1, frames set no data or error flag and idle lines do not set `idle`. A `rwu_set` pulse sets `rwu`.
- R10: With `wake_addr`=0, an idle line detected while asleep clears `rwu` and leaves `idle` at 0.
- R11: With `wake_addr`=1, a frame whose most significant data bit is 1 clears `rwu` and is received normally. Frames without that bit, and idle lines, leave `rwu` at 1.
- R12: A frame whose data bits and stop bit are all 0 sets `brk` along with `frame_err`.
- R13: `irq_rx` = (`full` OR `overrun`) AND `rie`; `irq_idle` = `idle` AND `ilie`.
- R14: When `clr_rx` falls in the same cycle as a frame completion, the clear takes effect first and the frame is accepted with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; 0 holds the framer and idle counter in reset |
| bit_stb | input | 1 | One-cycle strobe, one per recovered bit time |
| bit_val | input | 1 | Recovered line bit, valid with bit_stb |
| bit_noisy | input | 1 | Samples of this bit disagreed, valid with bit_stb |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| par_en | input | 1 | Parity checking enable |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| idle_after_stop | input | 1 | 1 starts idle counting after the stop bit |
| wake_addr | input | 1 | 1 wakes on an address mark, 0 on an idle line |
| rwu_set | input | 1 | Pulse that puts the receiver to sleep |
| clr_rx | input | 1 | Pulse that clears the data and error flags |
| clr_idle | input | 1 | Pulse that clears the idle flag |
| rie | input | 1 | Receive interrupt enable |
| ilie | input | 1 | Idle interrupt enable |
| rx_data | output | 8 | Low 8 data bits of the received character |
| rx_bit8 | output | 1 | Ninth data bit |
| full | output | 1 | Receive data register holds unread data |
| overrun | output | 1 | A frame was lost because the register was full |
| noise | output | 1 | Noise seen in the accepted frame |
| frame_err | output | 1 | Stop bit received as 0 |
| parity_err | output | 1 | Parity mismatch in the accepted frame |
| brk | output | 1 | Break character received |
| idle | output | 1 | Idle line detected |
| rwu | output | 1 | Receiver asleep |
| irq_rx | output | 1 | Data-full or overrun interrupt request |
| irq_idle | output | 1 | Idle interrupt request |

## Verification
Two events can land on the flag register in the same cycle: a frame completing and a software clear of the data flags. A second case is a frame completing in the same cycle that an address mark wakes the receiver. The first is provoked by pulsing `clr_rx` exactly in the cycle where the completed frame reaches the flag logic, with `full` still set from an earlier frame. It is judged by `full` being 1 with the new data and `overrun` being 0. For the second, a frame with the address mark is sent while asleep. The bench expects `rwu` to drop in the same update that raises `full` with that frame's data.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int DATA_W = 9;
    localparam int SR_W   = DATA_W + 2;
    localparam int CNT_W  = $clog2(SR_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              fe;
        logic              noisy;
    } frame_t;
endpackage

// File: rtl/rxf_shift.sv
module rxf_shift
    import rxf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rx_en,
    input  logic   bit_stb,
    input  logic   bit_val,
    input  logic   bit_noisy,
    input  logic   nine_bit,
    output logic   busy,
    output logic   start_evt,
    output logic   done,
    output frame_t frame
);
    localparam logic [CNT_W-1:0] LAST8 = CNT_W'(SR_W - 2);
    localparam logic [CNT_W-1:0] LAST9 = CNT_W'(SR_W - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] idx;
        logic [SR_W-1:0]  sr;
        logic             noisy;
        logic             done;
        frame_t           frame;
    } st_t;

    st_t st_d, st_q;
    logic [SR_W-1:0]  sr_new;
    logic [CNT_W-1:0] last_idx;
    logic             unused_lsb;

    assign sr_new     = {bit_val, st_q.sr[SR_W-1:1]};
    assign last_idx   = nine_bit ? LAST9 : LAST8;
    assign start_evt  = rx_en & bit_stb & ~st_q.busy & ~bit_val;
    assign unused_lsb = sr_new[0];

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!rx_en) begin
            st_d.busy = 1'b0;
            st_d.idx  = '0;
        end else if (bit_stb) begin
            if (!st_q.busy) begin
                if (!bit_val) begin
                    st_d.busy  = 1'b1;
                    st_d.idx   = CNT_W'(1);
                    st_d.sr    = {1'b0, {(SR_W-1){1'b1}}};
                    st_d.noisy = bit_noisy;
                end
            end else begin
                st_d.sr    = sr_new;
                st_d.noisy = st_q.noisy | bit_noisy;
                st_d.idx   = st_q.idx + 1'b1;
                if (st_q.idx == last_idx) begin
                    st_d.busy        = 1'b0;
                    st_d.idx         = '0;
                    st_d.done        = 1'b1;
                    st_d.frame.data  = nine_bit ? sr_new[SR_W-2:1]
                                                : {1'b0, sr_new[SR_W-2:2]};
                    st_d.frame.fe    = ~bit_val;
                    st_d.frame.noisy = st_q.noisy | bit_noisy;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign done  = st_q.done;
    assign frame = st_q.frame;

    AST_DONE_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_START_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> busy); // R1
endmodule

// File: rtl/rxf_idle.sv
module rxf_idle
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic bit_stb,
    input  logic bit_val,
    input  logic busy,
    input  logic start_evt,
    input  logic idle_after_stop,
    input  logic nine_bit,
    output logic idle_evt
);
    localparam logic [CNT_W-1:0] LEN8 = CNT_W'(SR_W - 1);
    localparam logic [CNT_W-1:0] LEN9 = CNT_W'(SR_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             evt;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] target;

    assign target = nine_bit ? LEN9 : LEN8;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (!rx_en) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (bit_stb) begin
            if (start_evt) st_d.armed = 1'b1;
            if (!bit_val || (idle_after_stop && busy)) begin
                st_d.cnt = '0;
            end else begin
                if (st_q.cnt != target) st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.armed && (st_q.cnt == target - 1'b1)) begin
                    st_d.evt   = 1'b1;
                    st_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle_evt = st_q.evt;

    AST_IDLE_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_evt |-> $past(bit_val) && $past(bit_stb)); // R7
    AST_IDLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_evt |=> !idle_evt); // R8
endmodule

// File: rtl/rxf_status.sv
module rxf_status
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  frame_t            frame,
    input  logic              idle_evt,
    input  logic              nine_bit,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              wake_addr,
    input  logic              rwu_set,
    input  logic              clr_rx,
    input  logic              clr_idle,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              ovr,
    output logic              nf,
    output logic              fe,
    output logic              pe,
    output logic              brk,
    output logic              idle,
    output logic              rwu
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
        logic              nf;
        logic              fe;
        logic              pe;
        logic              brk;
        logic              idle;
        logic              rwu;
    } st_t;

    st_t  st_d, st_q;
    logic msb;
    logic accept;

    assign msb    = nine_bit ? frame.data[DATA_W-1] : frame.data[DATA_W-2];
    assign accept = ~st_q.rwu | (wake_addr & msb);

    always_comb begin
        st_d = st_q;
        if (clr_rx) begin
            st_d.full = 1'b0;
            st_d.ovr  = 1'b0;
            st_d.nf   = 1'b0;
            st_d.fe   = 1'b0;
            st_d.pe   = 1'b0;
            st_d.brk  = 1'b0;
        end
        if (clr_idle) st_d.idle = 1'b0;
        if (done && accept) begin
            st_d.rwu = 1'b0;
            if (st_d.full) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.data = frame.data;
                st_d.full = 1'b1;
                st_d.nf   = frame.noisy;
                st_d.fe   = frame.fe;
                st_d.pe   = par_en & ((^frame.data) != par_odd);
                st_d.brk  = frame.fe & (frame.data == '0);
            end
        end
        if (idle_evt) begin
            if (st_q.rwu) begin
                if (!wake_addr) st_d.rwu = 1'b0;
            end else begin
                st_d.idle = 1'b1;
            end
        end
        if (rwu_set) st_d.rwu = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data = st_q.data;
    assign full = st_q.full;
    assign ovr  = st_q.ovr;
    assign nf   = st_q.nf;
    assign fe   = st_q.fe;
    assign pe   = st_q.pe;
    assign brk  = st_q.brk;
    assign idle = st_q.idle;
    assign rwu  = st_q.rwu;

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovr) |-> $stable(st_q.data)); // R6
    AST_NOISE_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.nf) |-> $rose(st_q.full)); // R4
    AST_FE_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fe) |-> $rose(st_q.full)); // R3
    AST_IDLE_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.idle) |-> !$past(st_q.rwu)); // R9
    AST_BRK_HAS_FE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.brk |-> st_q.fe); // R12
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       bit_stb,
    input  logic       bit_val,
    input  logic       bit_noisy,
    input  logic       nine_bit,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       idle_after_stop,
    input  logic       wake_addr,
    input  logic       rwu_set,
    input  logic       clr_rx,
    input  logic       clr_idle,
    input  logic       rie,
    input  logic       ilie,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       full,
    output logic       overrun,
    output logic       noise,
    output logic       frame_err,
    output logic       parity_err,
    output logic       brk,
    output logic       idle,
    output logic       rwu,
    output logic       irq_rx,
    output logic       irq_idle
);
    logic              busy, start_evt, done, idle_evt;
    frame_t            frame;
    logic [DATA_W-1:0] data;

    rxf_shift u_shift (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_stb(bit_stb),
        .bit_val(bit_val), .bit_noisy(bit_noisy), .nine_bit(nine_bit),
        .busy(busy), .start_evt(start_evt), .done(done), .frame(frame)
    );

    rxf_idle u_idle (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_stb(bit_stb),
        .bit_val(bit_val), .busy(busy), .start_evt(start_evt),
        .idle_after_stop(idle_after_stop), .nine_bit(nine_bit),
        .idle_evt(idle_evt)
    );

    rxf_status u_status (
        .clk(clk), .rst_n(rst_n), .done(done), .frame(frame),
        .idle_evt(idle_evt), .nine_bit(nine_bit), .par_en(par_en),
        .par_odd(par_odd), .wake_addr(wake_addr), .rwu_set(rwu_set),
        .clr_rx(clr_rx), .clr_idle(clr_idle), .data(data), .full(full),
        .ovr(overrun), .nf(noise), .fe(frame_err), .pe(parity_err),
        .brk(brk), .idle(idle), .rwu(rwu)
    );

    assign rx_data  = data[7:0];
    assign rx_bit8  = data[DATA_W-1];
    assign irq_rx   = (full | overrun) & rie;
    assign irq_idle = idle & ilie;
endmodule

// File: tb/test_rx_framer.sv
module test_rx_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, bit_stb = 1'b0, bit_val = 1'b1, bit_noisy = 1'b0;
    logic       nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic       idle_after_stop = 1'b0, wake_addr = 1'b0;
    logic       rwu_set = 1'b0, clr_rx = 1'b0, clr_idle = 1'b0;
    logic       rie = 1'b0, ilie = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8, full, overrun, noise, frame_err, parity_err;
    logic       brk, idle, rwu, irq_rx, irq_idle;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    rx_framer i_rx_framer (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_stb(bit_stb),
        .bit_val(bit_val), .bit_noisy(bit_noisy), .nine_bit(nine_bit),
        .par_en(par_en), .par_odd(par_odd), .idle_after_stop(idle_after_stop),
        .wake_addr(wake_addr), .rwu_set(rwu_set), .clr_rx(clr_rx),
        .clr_idle(clr_idle), .rie(rie), .ilie(ilie), .rx_data(rx_data),
        .rx_bit8(rx_bit8), .full(full), .overrun(overrun), .noise(noise),
        .frame_err(frame_err), .parity_err(parity_err), .brk(brk),
        .idle(idle), .rwu(rwu), .irq_rx(irq_rx), .irq_idle(irq_idle)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic b, input logic nz, input logic clr_after);
        @(negedge clk);
        bit_stb = 1'b1; bit_val = b; bit_noisy = nz;
        @(negedge clk);
        bit_stb = 1'b0; bit_noisy = 1'b0; bit_val = 1'b1;
        clr_rx = clr_after;
        @(negedge clk);
        clr_rx = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input int d, input logic stop, input int nz_mask,
                        input logic clr_end);
        int nb;
        nb = nine_bit ? 9 : 8;
        strobe(1'b0, nz_mask[0], 1'b0);
        for (int i = 0; i < nb; i++) strobe(d[i], nz_mask[i+1], 1'b0);
        strobe(stop, 1'b0, clr_end);
        repeat (2) @(negedge clk);
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) strobe(1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_rx = 1'b1; clr_idle = 1'b1;
        @(negedge clk); clr_rx = 1'b0; clr_idle = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2 full at reset", full, 0);
        chk("R7 idle at reset", idle, 0);
        chk("R9 rwu at reset", rwu, 0);
        chk("R13 irq_rx at reset", irq_rx, 0);
    endtask

    task automatic t_eight_bit();
        send(8'h5A, 1'b1, 0, 1'b0);
        chk("R1 data 8-bit", rx_data, 8'h5A);
        chk("R1 bit8 in 8-bit mode", rx_bit8, 0);
        chk("R2 full set", full, 1);
        chk("R3 no fe", frame_err, 0);
        chk("R13 irq_rx with rie", irq_rx, 1);
        rie = 1'b0; @(negedge clk);
        chk("R13 irq_rx masked", irq_rx, 0);
        rie = 1'b1;
        pulse_clr();
        chk("R2 clr_rx clears full", full, 0);
    endtask

    task automatic t_nine_bit();
        nine_bit = 1'b1;
        send(9'h1A5, 1'b1, 0, 1'b0);
        chk("R1 data 9-bit", rx_data, 8'hA5);
        chk("R1 ninth bit", rx_bit8, 1);
        nine_bit = 1'b0;
        pulse_clr();
    endtask

    task automatic t_framing();
        send(8'h3C, 1'b0, 0, 1'b0);
        chk("R3 fe on zero stop", frame_err, 1);
        chk("R12 no break with data", brk, 0);
        ones(1); pulse_clr();
        send(8'h00, 1'b0, 0, 1'b0);
        chk("R12 break flagged", brk, 1);
        chk("R3 fe on break", frame_err, 1);
        ones(1); pulse_clr();
    endtask

    task automatic t_noise_overrun();
        send(8'h11, 1'b1, 1 << 4, 1'b0);
        chk("R4 noise set", noise, 1);
        pulse_clr();
        send(8'h11, 1'b1, 0, 1'b0);
        chk("R4 clean frame", noise, 0);
        send(8'h22, 1'b1, 1 << 2, 1'b0);
        chk("R6 overrun set", overrun, 1);
        chk("R6 old data kept", rx_data, 8'h11);
        chk("R4 no noise on overrun", noise, 0);
        pulse_clr();
        chk("R6 overrun cleared", overrun, 0);
    endtask

    task automatic t_parity();
        par_en = 1'b1; par_odd = 1'b0;
        send(8'h03, 1'b1, 0, 1'b0);
        chk("R5 even parity ok", parity_err, 0);
        pulse_clr();
        send(8'h07, 1'b1, 0, 1'b0);
        chk("R5 even parity bad", parity_err, 1);
        pulse_clr();
        par_odd = 1'b1;
        send(8'h07, 1'b1, 0, 1'b0);
        chk("R5 odd parity ok", parity_err, 0);
        pulse_clr();
        par_en = 1'b0;
        send(8'h07, 1'b1, 0, 1'b0);
        chk("R5 parity disabled", parity_err, 0);
        pulse_clr();
    endtask

    task automatic t_idle_start();
        idle_after_stop = 1'b0; ilie = 1'b1;
        send(8'hFF, 1'b1, 0, 1'b0);
        chk("R7 not idle after frame", idle, 0);
        ones(1);
        chk("R7 idle counted from start", idle, 1);
        chk("R13 irq_idle", irq_idle, 1);
        pulse_clr();
        chk("R13 irq_idle cleared", irq_idle, 0);
    endtask

    task automatic t_idle_stop();
        idle_after_stop = 1'b1;
        send(8'hFF, 1'b1, 0, 1'b0);
        ones(9);
        chk("R8 not idle after 9 ones", idle, 0);
        ones(1);
        chk("R8 idle after 10 ones", idle, 1);
        pulse_clr();
    endtask

    task automatic t_wake_idle();
        wake_addr = 1'b0;
        @(negedge clk); rwu_set = 1'b1; @(negedge clk); rwu_set = 1'b0;
        chk("R9 rwu set", rwu, 1);
        send(8'h12, 1'b1, 0, 1'b0);
        chk("R9 frame suppressed", full, 0);
        chk("R9 still asleep", rwu, 1);
        ones(10);
        chk("R10 idle wakes", rwu, 0);
        chk("R10 idle flag stays low", idle, 0);
        send(8'h34, 1'b1, 0, 1'b0);
        chk("R10 receives after wake", rx_data, 8'h34);
        pulse_clr();
    endtask

    task automatic t_wake_addr();
        wake_addr = 1'b1;
        @(negedge clk); rwu_set = 1'b1; @(negedge clk); rwu_set = 1'b0;
        send(8'h05, 1'b1, 0, 1'b0);
        chk("R11 no mark ignored", full, 0);
        ones(10);
        chk("R11 idle does not wake", rwu, 1);
        chk("R9 idle suppressed", idle, 0);
        send(8'h85, 1'b1, 0, 1'b0);
        chk("R11 mark wakes", rwu, 0);
        chk("R11 mark frame received", rx_data, 8'h85);
        chk("R11 full on mark", full, 1);
        wake_addr = 1'b0;
        pulse_clr();
    endtask

    task automatic t_clear_collide();
        send(8'h41, 1'b1, 0, 1'b0);
        send(8'h42, 1'b1, 0, 1'b1);
        chk("R14 accepted on clear", rx_data, 8'h42);
        chk("R14 full", full, 1);
        chk("R14 no overrun", overrun, 0);
        pulse_clr();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; rx_en = 1'b1; rie = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_eight_bit();
        t_nine_bit();
        t_framing();
        t_noise_overrun();
        t_parity();
        t_idle_start();
        t_idle_stop();
        t_wake_idle();
        t_wake_addr();
        t_clear_collide();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule